// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked system and an external asynchronous static RAM of 131,072 bytes. It takes one read or write request at a time over a valid/ready handshake. It turns each request into a timed sequence on the memory pins: the address, an active-low select, an active-high select, an output enable and a write enable. It also controls the enable of the data-bus driver. The bidirectional data pins are assembled at the pad. The block provides the outgoing byte, the driver enable and the incoming byte as separate signals.

All timing is expressed in whole clock cycles. Each nanosecond limit of the chosen speed grade (10, 12 or 15 ns parts) is divided by the clock period and rounded up, with a floor of one cycle. Reads hold the memory selected with output enable low for the full access window. The byte is registered on the last cycle of that window, and a one-cycle valid pulse is raised with it.

Writes have three phases. First, output enable is held high long enough for the memory to release the bus. Then a write-enable pulse is given while the controller drives the data. Finally there is a recovery cycle. Between requests the memory is always returned to standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: In reset, and in the first cycle after it, the pins are at idle: `mem_sel_n`=1, `mem_sel`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_drv`=0, with `req_ready`=1 and `rd_valid`=0. A reset asserted during an access returns the pins to idle at once.
- R2: `mem_sel_n` is always the inverse of `mem_sel`. Both are active only from the cycle after a request is accepted until its sequence ends.
- R3: A read keeps the memory selected with `mem_oe_n`=0 and `mem_we_n`=1 for RD cycles. On the last of these cycles it registers `mem_dq_i` into `rd_data` and pulses `rd_valid` high for exactly one cycle. A write never raises `rd_valid`.
- R4: A write holds `mem_we_n` low for exactly PULSE cycles, with the memory selected and the address and data constant. The byte written is the one presented with the request.
- R5: `mem_dq_drv` is never 1 while `mem_oe_n` is 0. It turns on only after `mem_oe_n` has been high for at least HZ cycles.
- R6: `mem_dq_drv` is 1 only while `mem_we_n` is 0. It drops in the same cycle that `mem_we_n` rises.
- R7: A request is accepted at a clock edge where `req_valid`=1 and `req_ready`=1. `req_ready` then stays 0 for RD cycles on a read, or for HZ+PULSE+REC cycles on a write. A request held while `req_ready` is 0 is not accepted a second time.
- R8: Cycle counts are computed as ceiling(ns×1000 / CLK_PERIOD_PS), with a minimum of 1. With the defaults (4000 ps, 10 ns grade) this gives RD=3, HZ=2, PULSE=3 (the larger of write pulse and data setup) and REC=1.
- R9: Whenever `req_ready` is 1 the memory is deselected, with `mem_oe_n`=1 and `mem_we_n`=1.
- R10: `mem_addr` takes the request address in the cycle after acceptance and holds it unchanged until the access ends.
- R11: The cycle in which `rd_valid` pulses is also a cycle with `req_ready`=1. A request waiting there is accepted on the next edge, and the captured read byte is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rd_valid | output | 1 | One-cycle pulse, read byte valid |
| rd_data | output | 8 | Captured read byte |
| mem_addr | output | 17 | Memory address pins |
| mem_sel_n | output | 1 | Active-low memory select |
| mem_sel | output | 1 | Active-high memory select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_o | output | 8 | Byte driven onto the data pins |
| mem_dq_drv | output | 1 | Data pin driver enable |
| mem_dq_i | input | 8 | Byte sampled from the data pins |

## Verification
Two events can fall in the same cycle: the end-of-read valid pulse and the return of `req_ready`. A new request waiting on the handshake is therefore accepted on the very next edge. The bench provokes this by keeping `req_valid` high across a read and switching its fields to a write while the controller is busy. In the `rd_valid` cycle it checks that `req_ready` is 1 and that `rd_data` holds the stored byte. One cycle later it checks that the write has been accepted. A read-back then shows that the queued write landed, and the bus-sharing rules are watched on every cycle throughout.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

   // Sequencer phases
   typedef enum logic [2:0] {
      SQ_IDLE   = 3'd0,
      SQ_READ   = 3'd1,
      SQ_WSETUP = 3'd2,
      SQ_WPULSE = 3'd3,
      SQ_WRECOV = 3'd4
   } sq_state_e;

   // Pin levels for one phase
   typedef struct packed {
      logic sel_n;
      logic sel;
      logic oe_n;
      logic we_n;
      logic drv;
   } pin_ctl_t;

   // Timing limits of the memory, per speed grade
   typedef enum int {
      TK_CYCLE,
      TK_WPULSE,
      TK_WDATA,
      TK_ACCESS,
      TK_OEACC,
      TK_RELEASE
   } tkind_e;

   function automatic int grade_ps(input int grade, input tkind_e kind);
      int g;
      g = (grade < 0) ? 0 : ((grade > 2) ? 2 : grade);
      case (kind)
         TK_CYCLE:   return (g == 0) ? 10000 : ((g == 1) ? 12000 : 15000);
         TK_WPULSE:  return (g == 0) ?  9000 : ((g == 1) ? 10000 : 12000);
         TK_WDATA:   return (g == 0) ?  5000 : ((g == 1) ?  6000 :  7000);
         TK_ACCESS:  return (g == 0) ? 10000 : ((g == 1) ? 12000 : 15000);
         TK_OEACC:   return (g == 0) ?  5000 : ((g == 1) ?  6000 :  8000);
         TK_RELEASE: return (g == 0) ?  5000 : ((g == 1) ?  6000 :  8000);
         default:    return 15000;
      endcase
   endfunction

   // Ceiling division, never below one cycle
   function automatic int ps_to_cycles(input int ps, input int period_ps);
      int c;
      c = (ps + period_ps - 1) / period_ps;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic pin_ctl_t pins_for(input sq_state_e s);
      pin_ctl_t p;
      case (s)
         SQ_READ:   p = '{sel_n: 1'b0, sel: 1'b1, oe_n: 1'b0, we_n: 1'b1, drv: 1'b0};
         SQ_WSETUP: p = '{sel_n: 1'b0, sel: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};
         SQ_WPULSE: p = '{sel_n: 1'b0, sel: 1'b1, oe_n: 1'b1, we_n: 1'b0, drv: 1'b1};
         SQ_WRECOV: p = '{sel_n: 1'b0, sel: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};
         default:   p = '{sel_n: 1'b1, sel: 1'b0, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};
      endcase
      return p;
   endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
`timescale 1ns/1ps
module sram_ctrl_seq
   import sram_ctrl_pkg::*;
#(
   parameter int RD_CYC    = 3,
   parameter int HZ_CYC    = 2,
   parameter int PULSE_CYC = 3,
   parameter int REC_CYC   = 1
)(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  logic      start_wr,
   output sq_state_e state_q,
   output sq_state_e state_d,
   output logic      phase_last
);

   localparam int LONGEST = imax(imax(RD_CYC, HZ_CYC), imax(PULSE_CYC, REC_CYC));
   localparam int CNT_W   = (LONGEST < 2) ? 1 : $clog2(LONGEST);

   generate
      if (RD_CYC < 1 || HZ_CYC < 1 || PULSE_CYC < 1 || REC_CYC < 1) begin : g_bad_count
         $error("sram_ctrl_seq: every phase needs at least one cycle");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;

   function automatic logic [CNT_W-1:0] phase_end(input sq_state_e s);
      int len;
      case (s)
         SQ_READ:   len = RD_CYC;
         SQ_WSETUP: len = HZ_CYC;
         SQ_WPULSE: len = PULSE_CYC;
         SQ_WRECOV: len = REC_CYC;
         default:   len = 1;
      endcase
      return CNT_W'(len - 1);
   endfunction

   function automatic sq_state_e phase_next(input sq_state_e s);
      case (s)
         SQ_WSETUP: return SQ_WPULSE;
         SQ_WPULSE: return SQ_WRECOV;
         default:   return SQ_IDLE;
      endcase
   endfunction

   always_comb begin
      state_d    = state_q;
      cnt_d      = cnt_q;
      phase_last = (state_q != SQ_IDLE) && (cnt_q == phase_end(state_q));
      if (state_q == SQ_IDLE) begin
         cnt_d = '0;
         if (start) begin
            state_d = start_wr ? SQ_WSETUP : SQ_READ;
         end
      end else if (phase_last) begin
         cnt_d   = '0;
         state_d = phase_next(state_q);
      end else begin
         cnt_d = cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

endmodule

// File: rtl/sram_ctrl_pins.sv
`timescale 1ns/1ps
module sram_ctrl_pins
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  sq_state_e         state_d,
   input  logic              accept,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic              req_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_sel_n,
   output logic              mem_sel,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_drv
);

   pin_ctl_t ctl_d;
   assign ctl_d = pins_for(state_d);

   // Every memory pin comes straight from a flop
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_sel_n  <= 1'b1;
         mem_sel    <= 1'b0;
         mem_oe_n   <= 1'b1;
         mem_we_n   <= 1'b1;
         mem_dq_drv <= 1'b0;
         req_ready  <= 1'b1;
      end else begin
         mem_sel_n  <= ctl_d.sel_n;
         mem_sel    <= ctl_d.sel;
         mem_oe_n   <= ctl_d.oe_n;
         mem_we_n   <= ctl_d.we_n;
         mem_dq_drv <= ctl_d.drv;
         req_ready  <= (state_d == SQ_IDLE);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr <= '0;
         mem_dq_o <= '0;
      end else if (accept) begin
         mem_addr <= acc_addr;
         mem_dq_o <= acc_wdata;
      end
   end

endmodule

// File: rtl/sram_ctrl_capture.sv
`timescale 1ns/1ps
module sram_ctrl_capture #(
   parameter int DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_last,
   input  logic [DATA_W-1:0] mem_dq_i,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_last;
         if (rd_last) begin
            rd_data <= mem_dq_i;
         end
      end
   end

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W        = 17,
   parameter int DATA_W        = 8,
   parameter int CLK_PERIOD_PS = 4000,
   parameter int SPEED_GRADE   = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_sel_n,
   output logic              mem_sel,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_drv,
   input  logic [DATA_W-1:0] mem_dq_i
);

   localparam int P         = CLK_PERIOD_PS;
   localparam int G         = SPEED_GRADE;
   localparam int RD_CYC    = imax(imax(ps_to_cycles(grade_ps(G, TK_ACCESS), P),
                                        ps_to_cycles(grade_ps(G, TK_CYCLE), P)),
                                   ps_to_cycles(grade_ps(G, TK_OEACC), P));
   localparam int HZ_CYC    = ps_to_cycles(grade_ps(G, TK_RELEASE), P);
   localparam int PULSE_CYC = imax(ps_to_cycles(grade_ps(G, TK_WPULSE), P),
                                   ps_to_cycles(grade_ps(G, TK_WDATA), P));
   localparam int WC_CYC    = ps_to_cycles(grade_ps(G, TK_CYCLE), P);
   localparam int REC_CYC   = imax(1, WC_CYC - PULSE_CYC);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_async_ctrl: address and data widths must be positive");
      end
      if (SPEED_GRADE < 0 || SPEED_GRADE > 2) begin : g_bad_grade
         $error("sram_async_ctrl: speed grade must be 0, 1 or 2");
      end
      if (CLK_PERIOD_PS < 1) begin : g_bad_period
         $error("sram_async_ctrl: clock period must be positive");
      end
   endgenerate

   sq_state_e state_q;
   sq_state_e state_d;
   logic      phase_last;
   logic      accept;
   logic      rd_last;

   assign accept  = req_valid && req_ready;
   assign rd_last = (state_q == SQ_READ) && phase_last;

   sram_ctrl_seq #(
      .RD_CYC    (RD_CYC),
      .HZ_CYC    (HZ_CYC),
      .PULSE_CYC (PULSE_CYC),
      .REC_CYC   (REC_CYC)
   ) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .start_wr   (req_write),
      .state_q    (state_q),
      .state_d    (state_d),
      .phase_last (phase_last)
   );

   sram_ctrl_pins #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) pins_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .state_d    (state_d),
      .accept     (accept),
      .acc_addr   (req_addr),
      .acc_wdata  (req_wdata),
      .req_ready  (req_ready),
      .mem_addr   (mem_addr),
      .mem_sel_n  (mem_sel_n),
      .mem_sel    (mem_sel),
      .mem_oe_n   (mem_oe_n),
      .mem_we_n   (mem_we_n),
      .mem_dq_o   (mem_dq_o),
      .mem_dq_drv (mem_dq_drv)
   );

   sram_ctrl_capture #(
      .DATA_W (DATA_W)
   ) cap_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_last  (rd_last),
      .mem_dq_i (mem_dq_i),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk #(
   parameter int ADDR_W    = 17,
   parameter int HZ_CYC    = 2,
   parameter int PULSE_CYC = 3
)(
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rd_valid,
   input logic              mem_sel_n,
   input logic              mem_sel,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic              mem_dq_drv,
   input logic [ADDR_W-1:0] mem_addr
);

   logic [7:0] oe_hi_cnt;
   logic [7:0] we_lo_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_hi_cnt <= '0;
         we_lo_cnt <= '0;
      end else begin
         oe_hi_cnt <= !mem_oe_n ? 8'd0 : ((oe_hi_cnt == 8'hFF) ? oe_hi_cnt : oe_hi_cnt + 8'd1);
         we_lo_cnt <= mem_we_n  ? 8'd0 : ((we_lo_cnt == 8'hFF) ? we_lo_cnt : we_lo_cnt + 8'd1);
      end
   end

   assert_sel_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_sel_n == !mem_sel);

   assert_read_levels_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (mem_we_n && mem_sel && !mem_sel_n));

   assert_rdv_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   assert_write_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_sel && !mem_sel_n));

   assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_lo_cnt == 8'(PULSE_CYC)));

   assert_drv_oe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_drv |-> mem_oe_n);

   assert_drv_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dq_drv) |-> (oe_hi_cnt >= 8'(HZ_CYC)));

   assert_drv_in_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_drv |-> !mem_we_n);

   assert_drv_off_at_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> !mem_dq_drv);

   assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_idle_when_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_sel_n && !mem_sel && mem_oe_n && mem_we_n));

   assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
   .ADDR_W    (ADDR_W),
   .HZ_CYC    (HZ_CYC),
   .PULSE_CYC (PULSE_CYC)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .rd_valid   (rd_valid),
   .mem_sel_n  (mem_sel_n),
   .mem_sel    (mem_sel),
   .mem_oe_n   (mem_oe_n),
   .mem_we_n   (mem_we_n),
   .mem_dq_drv (mem_dq_drv),
   .mem_addr   (mem_addr)
);

// File: tb/sram_async_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;

   // R8: 4000 ps clock, 10 ns grade -> ceil(10000/4000)=3, ceil(5000/4000)=2,
   // pulse = max(ceil(9000/4000), ceil(5000/4000)) = 3, recovery = max(1, 3-3) = 1
   localparam int T_RD  = 3;
   localparam int T_HZ  = 2;
   localparam int T_PUL = 3;
   localparam int T_REC = 1;
   localparam int T_WR  = T_HZ + T_PUL + T_REC;
   localparam logic [7:0] FLOAT = 8'hEE;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [16:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        rd_valid;
   logic [7:0]  rd_data;
   logic [16:0] mem_addr;
   logic        mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_drv;
   logic [7:0]  mem_dq_o;
   logic [7:0]  mem_dq_i = FLOAT;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   sram_async_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
      .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_drv(mem_dq_drv),
      .mem_dq_i(mem_dq_i)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_idle(input string req);
      chk(mem_sel_n == 1'b1, {req, " sel_n"}, mem_sel_n, 1);
      chk(mem_sel == 1'b0,   {req, " sel"},   mem_sel, 0);
      chk(mem_oe_n == 1'b1,  {req, " oe_n"},  mem_oe_n, 1);
      chk(mem_we_n == 1'b1,  {req, " we_n"},  mem_we_n, 1);
      chk(mem_dq_drv == 1'b0, {req, " drv"},  mem_dq_drv, 0);
   endtask

   // Memory model and per-cycle bus rules
   logic [7:0] mem_model [logic [16:0]];
   logic prev_we_n = 1'b1;
   logic prev_drv = 1'b0;
   int   oe_hi_run = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         oe_hi_run = 0;
         prev_we_n = 1'b1;
         prev_drv  = 1'b0;
         mem_dq_i  = FLOAT;
      end else begin
         chk(mem_sel_n == !mem_sel, "R2 select pair", mem_sel_n, !mem_sel);
         chk(!(mem_dq_drv && !mem_oe_n), "R5 driver with oe low", mem_dq_drv, 0);
         if (mem_dq_drv && !prev_drv)
            chk(oe_hi_run >= T_HZ, "R5 oe high before drive", oe_hi_run, T_HZ);
         if (!prev_we_n && mem_we_n)
            chk(!mem_dq_drv, "R6 driver at we rise", mem_dq_drv, 0);
         if (mem_dq_drv)
            chk(!mem_we_n, "R6 driver outside pulse", mem_we_n, 0);
         if (!mem_sel_n && mem_sel && !mem_we_n) begin
            chk(mem_dq_drv, "R6 strobe without data", mem_dq_drv, 1);
            if (mem_dq_drv) mem_model[mem_addr] = mem_dq_o;
         end
         if (!mem_sel_n && mem_sel && !mem_oe_n && mem_we_n)
            mem_dq_i = mem_model.exists(mem_addr) ? mem_model[mem_addr] : 8'h00;
         else
            mem_dq_i = FLOAT;
         oe_hi_run = mem_oe_n ? oe_hi_run + 1 : 0;
         prev_we_n = mem_we_n;
         prev_drv  = mem_dq_drv;
      end
   end

   // Watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         total++;
         bad++;
         $display("FAIL R7 watchdog: cycles=%0d expected<=%0d", cyc, 20000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic run_op(input logic wr, input logic [16:0] a, input logic [7:0] d,
                         input logic [7:0] exp);
      int k;
      int we_lo;
      int drv_n;
      int rdv_at;
      bit addr_bad;
      logic [7:0] got;
      chk(req_ready, "R7 ready before request", req_ready, 1);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R7 busy after accept", req_ready, 0);
      k = 0; we_lo = 0; drv_n = 0; rdv_at = -1; addr_bad = 0; got = 8'h00;
      while (!req_ready && k < 40) begin
         if (!mem_we_n) we_lo++;
         if (mem_dq_drv) drv_n++;
         if (mem_addr != a) addr_bad = 1;
         @(negedge clk);
         k++;
         if (rd_valid) begin rdv_at = k; got = rd_data; end
      end
      chk(!addr_bad, "R10 address held", addr_bad, 0);
      chk_idle("R9 idle after access");
      if (wr) begin
         chk(k == T_WR, "R7 R8 write busy cycles", k, T_WR);
         chk(we_lo == T_PUL, "R4 R8 we low cycles", we_lo, T_PUL);
         chk(drv_n == T_PUL, "R6 driver cycles", drv_n, T_PUL);
         chk(rdv_at == -1, "R3 no read valid on write", rdv_at, -1);
      end else begin
         chk(k == T_RD, "R7 R8 read busy cycles", k, T_RD);
         chk(rdv_at == T_RD, "R3 read valid cycle", rdv_at, T_RD);
         chk(got == exp, "R3 read data", got, exp);
         chk(we_lo == 0, "R3 no we on read", we_lo, 0);
      end
   endtask

   // {write, addr[16:0], wdata, expected}
   localparam logic [33:0] VEC [10] = '{
      {1'b1, 17'h00000, 8'h5A, 8'h00},
      {1'b1, 17'h1FFFF, 8'hC3, 8'h00},
      {1'b0, 17'h00000, 8'h00, 8'h5A},
      {1'b0, 17'h1FFFF, 8'h00, 8'hC3},
      {1'b1, 17'h0AAAA, 8'hFF, 8'h00},
      {1'b1, 17'h15555, 8'h00, 8'h00},
      {1'b0, 17'h0AAAA, 8'h00, 8'hFF},
      {1'b0, 17'h15555, 8'h00, 8'h00},
      {1'b1, 17'h00000, 8'hA5, 8'h00},
      {1'b0, 17'h00000, 8'h00, 8'hA5}
   };

   initial begin
      int falls;
      logic pw;
      // R1: reset with a request pending
      req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00300; req_wdata = 8'h3C;
      repeat (4) @(negedge clk);
      chk_idle("R1 in reset");
      chk(req_ready, "R1 ready in reset", req_ready, 1);
      chk(!rd_valid, "R1 rd_valid in reset", rd_valid, 0);
      req_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk_idle("R1 after reset");
      chk(req_ready, "R1 ready after reset", req_ready, 1);
      chk(!rd_valid, "R1 rd_valid after reset", rd_valid, 0);

      // R3 R4: vector table
      for (int i = 0; i < 10; i++)
         run_op(VEC[i][33], VEC[i][32:16], VEC[i][15:8], VEC[i][7:0]);

      // R11: read-valid cycle coincides with acceptance of the next request
      run_op(1'b1, 17'h00123, 8'h77, 8'h00);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h00123;
      @(negedge clk);
      req_write = 1'b1; req_addr = 17'h00124; req_wdata = 8'h99;
      repeat (T_RD) @(negedge clk);
      chk(rd_valid && req_ready, "R11 valid and ready together", {rd_valid, req_ready}, 3);
      chk(rd_data == 8'h77, "R11 read byte", rd_data, 8'h77);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R11 next request accepted", req_ready, 0);
      chk(!rd_valid, "R3 read valid one cycle", rd_valid, 0);
      chk(rd_data == 8'h77, "R11 read byte held", rd_data, 8'h77);
      while (!req_ready) @(negedge clk);
      run_op(1'b0, 17'h00124, 8'h00, 8'h99);

      // R7: request held through a write is taken once
      req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00200; req_wdata = 8'h11;
      falls = 0; pw = mem_we_n;
      for (int k = 0; k <= T_WR; k++) begin
         @(negedge clk);
         if (pw && !mem_we_n) falls++;
         pw = mem_we_n;
         if (k < T_WR) chk(!req_ready, "R7 held request busy", req_ready, 0);
      end
      req_valid = 1'b0;
      chk(falls == 1, "R7 single write for held request", falls, 1);
      @(negedge clk);
      chk(req_ready, "R7 no second accept", req_ready, 1);
      run_op(1'b0, 17'h00200, 8'h00, 8'h11);

      // R1: reset in the middle of a write pulse
      req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00300; req_wdata = 8'h3C;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (T_HZ + 1) @(negedge clk);
      chk(!mem_we_n, "R4 pulse under way", mem_we_n, 0);
      rst_n = 1'b0;
      #1;
      chk_idle("R1 reset mid write");
      chk(req_ready, "R1 ready after mid reset", req_ready, 1);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_idle("R1 after mid reset");
      run_op(1'b0, 17'h1FFFF, 8'h00, 8'hC3);

      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule